// File: doc/BRIEF.md
# USB Host Packet Transmitter

This block turns host-side packet requests into an ordered stream of symbols for a downstream serializer that handles NRZI coding and bit stuffing. One request builds a whole packet. A handshake packet carries no payload. A token packet carries an address and an endpoint. A start-of-frame packet carries an internally kept frame number. A data packet carries a byte stream supplied by the caller. The block computes the 5-bit and 16-bit checksums itself.

When a low-speed device sits behind a hub, the host first sends a preamble at full speed. The block emits the preamble as individual line states, so that the serializer never appends an end-of-packet to it. It then raises a low-speed flag for the serializer and pads with idle bit periods. After the following packet completes, the flag drops back to full speed. A one-cycle done pulse reports the moment the serializer has drained a packet.

Top module: `usb_host_pkt_tx`

## Requirements
- R1: After reset, cmd_ready is 1 and out_valid, done and low_speed are 0.
- R2: Symbol encoding on out_code: bit 8 set means a byte in bits 7..0. Bit 8 clear means a line code in bits 2..0: 0 idle, 1 SE0, 2 K, 3 J, 4 EOP sequence, 5 SYNC sequence. Command kinds on cmd_kind are 0 ACK, 1 NAK, 2 STALL, 3 OUT, 4 IN, 5 SETUP, 6 SOF, 7 DATA, 8 PRE. A handshake command emits SYNC, then its PID byte (ACK 0x4B, NAK 0x5A, STALL 0x78), then EOP.
- R3: A token command emits SYNC, then its PID (OUT 0x87, IN 0x96, SETUP 0xB4), then two bytes, then EOP. The two bytes are the low and high halves of a 16-bit word that holds the address in bits 6..0, the endpoint in bits 10..7 and the checksum in bits 15..11.
- R4: The 5-bit checksum starts at all ones. It takes the 11 payload bits least significant first through the reflected polynomial 0x05 and is complemented at the end.
- R5: A SOF command emits PID 0xA5 with the 11-bit frame number as payload, in the same layout as R3. The first SOF after reset carries 0, and each SOF advances the number by one, wrapping from 2047 to 0.
- R6: A data command emits SYNC, then PID 0xC3 when cmd_toggle is 0 or 0xD2 when it is 1, then every supplied byte in order up to and including the one marked dat_last, then two checksum bytes, then EOP.
- R7: The 16-bit checksum starts at 0xFFFF, takes each byte least significant bit first through the reflected polynomial 0x8005, and is sent complemented with the low byte first. With cmd_zlp set, no bytes are taken and the checksum bytes are 0x00 0x00.
- R8: A PRE command emits exactly 18 line states, with no SYNC and no EOP code. The states come from 0b11_1011111011010101 taken least significant bit first, with 1 giving K and 0 giving J. Four idle codes follow, and low_speed is 1 once the request completes.
- R9: low_speed returns to 0 when the next packet that is not a preamble completes.
- R10: While out_valid is 1 and out_ready is 0, out_code holds its value, so stalls never change the symbol sequence.
- R11: Once the final symbol is accepted, done pulses for one cycle in the cycle after ser_empty is seen high, and cmd_ready rises with it. Neither happens while ser_empty stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_valid | input | 1 | request present |
| cmd_ready | output | 1 | block idle, request taken |
| cmd_kind | input | 4 | packet kind (R2 codes) |
| cmd_addr | input | 7 | device address for tokens |
| cmd_endp | input | 4 | endpoint for tokens |
| cmd_toggle | input | 1 | data PID select |
| cmd_zlp | input | 1 | data packet with no payload |
| dat_valid | input | 1 | payload byte present |
| dat_ready | output | 1 | payload byte taken |
| dat_byte | input | 8 | payload byte |
| dat_last | input | 1 | final payload byte |
| out_valid | output | 1 | symbol present |
| out_ready | input | 1 | serializer takes symbol |
| out_code | output | 9 | symbol (R2 encoding) |
| ser_empty | input | 1 | serializer buffer drained |
| low_speed | output | 1 | serializer speed and polarity select |
| done | output | 1 | packet complete pulse |

## Verification
The wrap of the frame number is the state hardest to reach from the ports, because it needs 2048 start-of-frame requests. The bench therefore issues a full run of them back to back. It checks the payload of the first SOF, of the last SOF before the wrap and of the SOF just after it. The handover between the preamble and the low-speed packet that follows is reached with a PRE request followed at once by a token. The bench samples low_speed around both completions.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  typedef enum logic [3:0] {
    K_ACK = 4'd0, K_NAK = 4'd1, K_STALL = 4'd2, K_OUT = 4'd3, K_IN = 4'd4,
    K_SETUP = 4'd5, K_SOF = 4'd6, K_DATA = 4'd7, K_PRE = 4'd8
  } kind_t;

  localparam logic [2:0] LC_IDLE = 3'd0;
  localparam logic [2:0] LC_SE0  = 3'd1;
  localparam logic [2:0] LC_K    = 3'd2;
  localparam logic [2:0] LC_J    = 3'd3;
  localparam logic [2:0] LC_EOP  = 3'd4;
  localparam logic [2:0] LC_SYNC = 3'd5;

  function automatic logic [7:0] pid_of(input kind_t k, input logic tog);
    case (k)
      K_ACK:   return 8'h4B;
      K_NAK:   return 8'h5A;
      K_STALL: return 8'h78;
      K_OUT:   return 8'h87;
      K_IN:    return 8'h96;
      K_SETUP: return 8'hB4;
      K_SOF:   return 8'hA5;
      K_DATA:  return tog ? 8'hD2 : 8'hC3;
      default: return 8'h3C;
    endcase
  endfunction

  function automatic logic [4:0] crc5_of(input logic [10:0] p);
    logic [4:0] r;
    logic fb;
    r = 5'h1F;
    for (int i = 0; i < 11; i++) begin
      fb = r[0] ^ p[i];
      r = r >> 1;
      if (fb) r = r ^ 5'h14;
    end
    return ~r;
  endfunction

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ b[i];
      r = r >> 1;
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction
endpackage

// File: rtl/usb_tx_frame_ctr.sv
module usb_tx_frame_ctr #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bump,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk) begin
    if (!rst_n) frame <= '0;
    else if (bump) frame <= frame + 1'b1;
  end
endmodule

// File: rtl/usb_tx_crc16.sv
module usb_tx_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  byte_in,
  output logic [15:0] crc
);
  import usb_tx_pkg::*;
  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc <= 16'hFFFF;
    else if (en) crc <= crc16_step(crc, byte_in);
  end
endmodule

// File: rtl/usb_host_pkt_tx.sv
module usb_host_pkt_tx #(
  parameter int          FRAME_W = 11,
  parameter int          PRE_LEN = 18,
  parameter logic [PRE_LEN-1:0] PRE_PAT = 18'b11_1011111011010101,
  parameter int          PRE_GAP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [3:0] cmd_kind,
  input  logic [6:0] cmd_addr,
  input  logic [3:0] cmd_endp,
  input  logic       cmd_toggle,
  input  logic       cmd_zlp,
  input  logic       dat_valid,
  output logic       dat_ready,
  input  logic [7:0] dat_byte,
  input  logic       dat_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [8:0] out_code,
  input  logic       ser_empty,
  output logic       low_speed,
  output logic       done
);
  import usb_tx_pkg::*;
  localparam int CMAX = (PRE_LEN > PRE_GAP) ? PRE_LEN : PRE_GAP;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SYNC, S_PID, S_TOK0, S_TOK1, S_BODY, S_CRCL, S_CRCH,
    S_EOP, S_PRE, S_GAP, S_WAIT
  } st_t;

  st_t         st;
  kind_t       kind_q;
  logic [7:0]  pid_q;
  logic [15:0] tok_q;
  logic        zlp_q;
  logic [CW-1:0] cnt_q;
  logic        ls_q, done_q;

  kind_t        kind_in;
  logic         cmd_fire, out_fire, sof_bump, crc_clear, crc_en;
  logic         in_body, pre_last_fire;
  logic [10:0]  payload;
  logic [15:0]  crc_reg;
  logic [FRAME_W-1:0] frame;

  assign kind_in  = kind_t'(cmd_kind);
  assign cmd_ready = (st == S_IDLE);
  assign cmd_fire = cmd_valid && cmd_ready;
  assign out_fire = out_valid && out_ready;
  assign in_body  = (st == S_BODY);
  assign sof_bump = cmd_fire && (kind_in == K_SOF);
  assign crc_clear = cmd_fire;
  assign crc_en    = in_body && out_fire;
  assign pre_last_fire = (st == S_PRE) && out_fire && (cnt_q == CW'(PRE_LEN - 1));
  assign payload  = (kind_in == K_SOF) ? 11'(frame) : {cmd_endp, cmd_addr};
  assign dat_ready = in_body && out_ready;
  assign low_speed = ls_q;
  assign done = done_q;

  usb_tx_frame_ctr #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .bump(sof_bump), .frame(frame));

  usb_tx_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clear), .en(crc_en),
    .byte_in(dat_byte), .crc(crc_reg));

  always_comb begin
    out_valid = 1'b1;
    out_code  = {6'd0, LC_IDLE};
    case (st)
      S_SYNC: out_code = {6'd0, LC_SYNC};
      S_PID:  out_code = {1'b1, pid_q};
      S_TOK0: out_code = {1'b1, tok_q[7:0]};
      S_TOK1: out_code = {1'b1, tok_q[15:8]};
      S_BODY: begin out_valid = dat_valid; out_code = {1'b1, dat_byte}; end
      S_CRCL: out_code = {1'b1, ~crc_reg[7:0]};
      S_CRCH: out_code = {1'b1, ~crc_reg[15:8]};
      S_EOP:  out_code = {6'd0, LC_EOP};
      S_PRE:  out_code = {6'd0, PRE_PAT[cnt_q] ? LC_K : LC_J};
      S_GAP:  out_code = {6'd0, LC_IDLE};
      default: out_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind_q <= K_ACK; pid_q <= '0; tok_q <= '0;
      zlp_q <= 1'b0; cnt_q <= '0; ls_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          kind_q <= kind_in;
          pid_q  <= pid_of(kind_in, cmd_toggle);
          tok_q  <= {crc5_of(payload), payload};
          zlp_q  <= cmd_zlp;
          cnt_q  <= '0;
          if (kind_in == K_PRE) st <= S_PRE;
          else if (kind_in <= K_DATA) st <= S_SYNC;
          else st <= S_WAIT;
        end
        S_SYNC: if (out_fire) st <= S_PID;
        S_PID: if (out_fire) begin
          if (kind_q <= K_STALL) st <= S_EOP;
          else if (kind_q == K_DATA) st <= zlp_q ? S_CRCL : S_BODY;
          else st <= S_TOK0;
        end
        S_TOK0: if (out_fire) st <= S_TOK1;
        S_TOK1: if (out_fire) st <= S_EOP;
        S_BODY: if (out_fire && dat_last) st <= S_CRCL;
        S_CRCL: if (out_fire) st <= S_CRCH;
        S_CRCH: if (out_fire) st <= S_EOP;
        S_EOP:  if (out_fire) st <= S_WAIT;
        S_PRE: if (out_fire) begin
          if (pre_last_fire) begin st <= S_GAP; cnt_q <= '0; ls_q <= 1'b1; end
          else cnt_q <= cnt_q + 1'b1;
        end
        S_GAP: if (out_fire) begin
          if (cnt_q == CW'(PRE_GAP - 1)) st <= S_WAIT;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_WAIT: if (ser_empty) begin
          st <= S_IDLE;
          done_q <= 1'b1;
          if (kind_q != K_PRE) ls_q <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: a stalled symbol outside the payload phase does not move
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !in_body) |=> (out_valid && $stable(out_code)));
  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: an idle block offers no symbol
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !out_valid);
  // R8: the last preamble state switches the link to low speed
  a_r8_speed_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    pre_last_fire |=> low_speed);
  // R6: payload bytes are taken only when the serializer takes them
  a_r6_dat_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_ready && dat_valid) |-> out_fire);
endmodule

// File: tb/usb_host_pkt_tx_test.sv
module usb_host_pkt_tx_test;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready, cmd_toggle = 0, cmd_zlp = 0;
  logic [3:0] cmd_kind = 0, cmd_endp = 0;
  logic [6:0] cmd_addr = 0;
  logic dat_valid = 0, dat_ready, dat_last = 0;
  logic [7:0] dat_byte = 0;
  logic out_valid, out_ready = 1, ser_empty = 1, low_speed, done;
  logic [8:0] out_code;

  int checks = 0, errors = 0, cyc = 0;
  bit stall = 0;
  bit finished = 0;
  logic [8:0] cap[$];
  logic [8:0] exp_q[$];
  logic [7:0] src[$];
  int fexp = 0;

  always #4 clk = ~clk;

  usb_host_pkt_tx uut (.*);

  always @(negedge clk) begin
    cyc++;
    out_ready = stall ? (cyc % 3 != 0) : 1'b1;
    dat_valid = (src.size() != 0) && !(stall && cyc % 5 == 0);
    dat_byte  = src.size() != 0 ? src[0] : 8'h00;
    dat_last  = src.size() == 1;
    #1;
    if (rst_n && out_valid && out_ready) cap.push_back(out_code);
    if (rst_n && dat_valid && dat_ready) void'(src.pop_front());
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [4:0] ref_crc5(input logic [10:0] p);
    logic [4:0] r = 5'h1F, o;
    for (int i = 0; i < 11; i++) begin
      logic fb = r[4] ^ p[i];
      r = {r[3:0], 1'b0};
      if (fb) r = r ^ 5'h05;
    end
    r = ~r;
    for (int i = 0; i < 5; i++) o[i] = r[4-i];
    return o;
  endfunction

  function automatic logic [15:0] ref_crc16(input logic [7:0] d[$]);
    logic [15:0] r = 16'hFFFF, o;
    foreach (d[j]) for (int i = 0; i < 8; i++) begin
      logic fb = r[15] ^ d[j][i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h8005;
    end
    r = ~r;
    for (int i = 0; i < 16; i++) o[i] = r[15-i];
    return o;
  endfunction

  function automatic void eb(input logic [7:0] b); exp_q.push_back({1'b1, b}); endfunction
  function automatic void es(input logic [2:0] c); exp_q.push_back({6'd0, c}); endfunction

  task automatic compare(input string req);
    bit ok = (cap.size() == exp_q.size());
    int a = cap.size(), e = exp_q.size();
    if (ok) foreach (exp_q[i]) if (ok && cap[i] !== exp_q[i]) begin
      ok = 0; a = cap[i]; e = exp_q[i];
    end
    check(ok, req, a, e);
    cap.delete(); exp_q.delete();
  endtask

  task automatic run_cmd(input int kind, input int addr, input int endp, input bit tog, input bit zlp);
    int t = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_kind = 4'(kind); cmd_addr = 7'(addr); cmd_endp = 4'(endp);
    cmd_toggle = tog; cmd_zlp = zlp;
    #2;
    while (!cmd_ready) begin @(negedge clk); #2; end
    @(negedge clk); cmd_valid = 0; #2;
    while (!done && t < 500) begin @(negedge clk); #2; t++; end
    check(done === 1'b1, "R11 done seen", done, 1);
    @(negedge clk); #2;
    check(done === 1'b0 && cmd_ready === 1'b1, "R11 single pulse", done, 0);
  endtask

  task automatic exp_token(input logic [7:0] pid, input logic [10:0] p);
    logic [15:0] w = {ref_crc5(p), p};
    es(5); eb(pid); eb(w[7:0]); eb(w[15:8]); es(4);
  endtask

  task automatic t_reset();
    check(cmd_ready === 1 && out_valid === 0 && done === 0 && low_speed === 0,
          "R1 reset state", {cmd_ready, out_valid, done, low_speed}, 4'b1000);
  endtask

  task automatic t_handshake();
    logic [7:0] pids[3] = '{8'h4B, 8'h5A, 8'h78};
    for (int k = 0; k < 3; k++) begin
      run_cmd(k, 0, 0, 0, 0);
      es(5); eb(pids[k]); es(4);
      compare("R2 handshake");
    end
  endtask

  task automatic t_tokens();
    run_cmd(3, 7'h15, 4'hE, 0, 0); exp_token(8'h87, {4'hE, 7'h15}); compare("R3 R4 OUT token");
    run_cmd(4, 7'h7F, 4'hF, 0, 0); exp_token(8'h96, {4'hF, 7'h7F}); compare("R3 R4 IN token");
    run_cmd(5, 7'h00, 4'h0, 0, 0); exp_token(8'hB4, 11'h000); compare("R3 R4 SETUP token");
  endtask

  task automatic t_sof();
    run_cmd(6, 0, 0, 0, 0); exp_token(8'hA5, 11'(fexp)); compare("R5 first SOF is 0");
    fexp++;
    for (int i = 0; i < 2046; i++) begin run_cmd(6, 0, 0, 0, 0); fexp++; end
    cap.delete();
    run_cmd(6, 0, 0, 0, 0); exp_token(8'hA5, 11'd2047); compare("R5 SOF 2047");
    run_cmd(6, 0, 0, 0, 0); exp_token(8'hA5, 11'd0); compare("R5 SOF wraps to 0");
  endtask

  task automatic t_data();
    logic [7:0] d[$];
    logic [15:0] c;
    d = '{8'h05, 8'h0C, 8'h09, 8'h01, 8'hA1, 8'h01, 8'h19, 8'h00};
    c = ref_crc16(d);
    stall = 1;
    src = d;
    run_cmd(7, 0, 0, 0, 0);
    es(5); eb(8'hC3); foreach (d[i]) eb(d[i]); eb(c[7:0]); eb(c[15:8]); es(4);
    compare("R6 R7 R10 DATA0 under stalls");
    stall = 0;
    d = '{8'h3A};
    c = ref_crc16(d);
    src = d;
    run_cmd(7, 0, 0, 1, 0);
    es(5); eb(8'hD2); eb(8'h3A); eb(c[7:0]); eb(c[15:8]); es(4);
    compare("R6 R7 DATA1 one byte");
    run_cmd(7, 0, 0, 0, 1);
    es(5); eb(8'hC3); eb(8'h00); eb(8'h00); es(4);
    compare("R7 zero-length data");
  endtask

  task automatic t_pre();
    logic [17:0] pat = 18'b11_1011111011010101;
    check(low_speed === 0, "R9 full speed before PRE", low_speed, 0);
    run_cmd(8, 0, 0, 0, 0);
    for (int i = 0; i < 18; i++) es(pat[i] ? 3'd2 : 3'd3);
    for (int i = 0; i < 4; i++) es(0);
    compare("R8 preamble states");
    check(low_speed === 1, "R8 low speed after PRE", low_speed, 1);
    run_cmd(4, 7'h21, 4'h1, 0, 0); exp_token(8'h96, {4'h1, 7'h21});
    compare("R3 token after PRE");
    check(low_speed === 0, "R9 full speed restored", low_speed, 0);
  endtask

  task automatic t_busy();
    bit seen = 0;
    ser_empty = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_kind = 0; #2;
    @(negedge clk); cmd_valid = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); #2; if (done || cmd_ready) seen = 1; end
    check(!seen, "R11 no done while serializer busy", seen, 0);
    ser_empty = 1;
    @(negedge clk); #2;
    check(done === 1 && cmd_ready === 1, "R11 done after drain", {done, cmd_ready}, 2'b11);
    es(5); eb(8'h4B); es(4);
    compare("R2 ACK with busy serializer");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2; t_reset();
    rst_n = 1;
    t_handshake();
    t_tokens();
    t_data();
    t_pre();
    t_busy();
    t_sof();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule